// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs one string instruction on a byte-addressed memory: copy an element from the source area to the destination area, compare a source element with a destination element, scan the destination for a match with the accumulator, load the accumulator from the source, or store the accumulator to the destination. Each operation runs either once or under one of three repeat modes. The first repeat mode counts only. The second also stops when two elements differ. The third also stops when two elements are equal. The block holds working copies of the source pointer, destination pointer, count, accumulator and zero flag. It steps the pointers after every element and hands all of them back when it finishes.

A controller presents the operands, segment bases, direction and width, then pulses `start`. The sequencer issues memory requests over a single-port request/ready interface. It forms 20-bit addresses from a 16-bit segment base shifted left by four plus a 16-bit offset. It raises `done` for one cycle when the work is over. The results stay on the output ports until the next start.

Top module: `strop_seq`

## Requirements
- R1: Source elements are read at src_seg*16 + src_ptr and destination elements are accessed at dst_seg*16 + dst_ptr, modulo 2^20. `mem_wide` is 1 for 16-bit elements, and byte data travels on bits 7:0 of `mem_wdata` and `mem_rdata`.
- R2: After each element, the pointer of each area the operation touched moves by 1 (byte) or 2 (word). It moves up when `dir_down`=0 and down when `dir_down`=1. The source pointer moves for copy, compare and load. The destination pointer moves for copy, compare, scan and store.
- R3: Under any repeat mode (`rep_mode` 1, 2 or 3), the count drops by one per element and repetition ends when it reaches zero. After a full repeated byte copy, the count is 0 and both pointers sit one past the last byte moved.
- R4: Under a repeat mode, a count of zero at start processes no element: no memory request, pointers, count, accumulator and flag unchanged, then `done`.
- R5: With `rep_mode`=0, exactly one element is processed and the count is returned unchanged.
- R6: Compare (`op_sel`=1) sets the zero flag when source element minus destination element is zero at the element width. Scan (`op_sel`=2) does the same for accumulator minus destination element. Neither operation writes memory or the accumulator.
- R7: Mode 2 ends repetition after a compare or scan element that clears the zero flag, and mode 3 ends it after one that sets the flag. Mode 1 ignores the flag.
- R8: Copy (`op_sel`=0) writes the source element to the destination. Load (`op_sel`=3) replaces the accumulator, or only its low byte for byte elements. Store (`op_sel`=4) writes the accumulator, or its low byte. These three leave the zero flag unchanged.
- R9: A request keeps its address, direction and data stable until `mem_ready` is seen. Only copy and store ever issue writes.
- R10: `done` is a one-cycle pulse, `busy` is high from the cycle after start until `done`, and `start` has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_sel | input | 3 | 0 copy, 1 compare, 2 scan, 3 load, 4 store |
| rep_mode | input | 2 | 0 once, 1 count only, 2 while equal, 3 while not equal |
| wide | input | 1 | 1 = 16-bit elements, 0 = bytes |
| dir_down | input | 1 | 1 = pointers step downward |
| src_seg | input | 16 | Source segment base |
| dst_seg | input | 16 | Destination segment base |
| src_ptr_in | input | 16 | Initial source offset |
| dst_ptr_in | input | 16 | Initial destination offset |
| count_in | input | 16 | Initial repeat count |
| acc_in | input | 16 | Initial accumulator |
| zf_in | input | 1 | Initial zero flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| src_ptr | output | 16 | Current source offset |
| dst_ptr | output | 16 | Current destination offset |
| count | output | 16 | Current repeat count |
| acc | output | 16 | Current accumulator |
| zf | output | 1 | Current zero flag |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | Request is a 16-bit access |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the current request |

## Verification
A corrupted pointer or count has no local symptom while repetition continues. It first shows up as a wrong address on the next request, one or two cycles after the element step. Otherwise it shows up in the count returned at `done`, and a misjudged stop condition shifts that count by the number of extra or missing elements. A wrong zero flag or accumulator stays invisible until `done`, or until the following scan compares against it. For that reason every run compares the full returned state and the whole memory image against an independent model.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    OP_MOVE  = 3'd0,
    OP_CMP   = 3'd1,
    OP_SCAN  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } sop_e;

  typedef enum logic [1:0] {
    RP_NONE     = 2'd0,
    RP_PLAIN    = 2'd1,
    RP_WHILE_EQ = 2'd2,
    RP_WHILE_NE = 2'd3
  } rpt_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RD_SRC,
    ST_RD_DST,
    ST_WR_DST,
    ST_STEP,
    ST_DONE
  } st_e;

  // operation reads the source area
  function automatic logic reads_src(sop_e op);
    return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_LOAD);
  endfunction

  // operation touches the destination area
  function automatic logic touches_dst(sop_e op);
    return (op == OP_MOVE) || (op == OP_CMP) || (op == OP_SCAN) || (op == OP_STORE);
  endfunction

  // operation produces a zero flag
  function automatic logic sets_zf(sop_e op);
    return (op == OP_CMP) || (op == OP_SCAN);
  endfunction

endpackage

// File: rtl/strop_agen.sv
module strop_agen #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int BASE_W = SEG_W + SHIFT;

  logic [BASE_W-1:0] base;

  assign base   = {seg_i, {SHIFT{1'b0}}};
  assign addr_o = ADDR_W'(base) + ADDR_W'(off_i);
endmodule

// File: rtl/strop_ptr_step.sv
module strop_ptr_step #(
  parameter int PTR_W = 16
) (
  input  logic [PTR_W-1:0] ptr_i,
  input  logic             en_i,
  input  logic             wide_i,
  input  logic             down_i,
  output logic [PTR_W-1:0] ptr_o
);
  localparam logic [PTR_W-1:0] STEP_B = PTR_W'(1);
  localparam logic [PTR_W-1:0] STEP_W = PTR_W'(2);

  logic [PTR_W-1:0] delta;

  assign delta = wide_i ? STEP_W : STEP_B;

  always_comb begin
    if (!en_i)       ptr_o = ptr_i;
    else if (down_i) ptr_o = ptr_i - delta;
    else             ptr_o = ptr_i + delta;
  end
endmodule

// File: rtl/strop_zcmp.sv
module strop_zcmp #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] lhs_i,
  input  logic [DATA_W-1:0] rhs_i,
  input  logic              wide_i,
  output logic              zero_o
);
  localparam int HALF = DATA_W / 2;

  function automatic logic diff_is_zero(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, logic w);
    logic [DATA_W-1:0] d;
    d = a - b;
    return w ? (d == '0) : (d[HALF-1:0] == '0);
  endfunction

  assign zero_o = diff_is_zero(lhs_i, rhs_i, wide_i);
endmodule

// File: rtl/strop_seq.sv
module strop_seq
  import strop_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SEG_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op_sel,
  input  logic [1:0]        rep_mode,
  input  logic              wide,
  input  logic              dir_down,
  input  logic [SEG_W-1:0]  src_seg,
  input  logic [SEG_W-1:0]  dst_seg,
  input  logic [DATA_W-1:0] src_ptr_in,
  input  logic [DATA_W-1:0] dst_ptr_in,
  input  logic [DATA_W-1:0] count_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              zf_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] src_ptr,
  output logic [DATA_W-1:0] dst_ptr,
  output logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] acc,
  output logic              zf,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int BYTE_W = DATA_W / 2;
  localparam int N_PTR  = 2;

  st_e               st_q, st_nxt;
  sop_e              op_q;
  rpt_e              rp_q;
  logic              wide_q, dir_q, zf_q;
  logic [SEG_W-1:0]  sseg_q, dseg_q;
  logic [DATA_W-1:0] si_q, di_q, cx_q, acc_q, tmp_q;

  // named internal events
  logic              elem_done;
  logic              cx_exhausted;
  logic              stop_now;
  logic              xfer;
  logic              cmp_zero;
  logic [DATA_W-1:0] cx_after;
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] wr_src;
  logic [ADDR_W-1:0] addr_src, addr_dst;

  // pointer steppers: index 0 source, 1 destination
  logic [DATA_W-1:0] ptr_cur [N_PTR];
  logic [DATA_W-1:0] ptr_nxt [N_PTR];
  logic              ptr_en  [N_PTR];

  assign ptr_cur[0] = si_q;
  assign ptr_cur[1] = di_q;
  assign ptr_en[0]  = reads_src(op_q);
  assign ptr_en[1]  = touches_dst(op_q);

  for (genvar g = 0; g < N_PTR; g++) begin : g_step
    strop_ptr_step #(.PTR_W(DATA_W)) u_step (
      .ptr_i  (ptr_cur[g]),
      .en_i   (ptr_en[g]),
      .wide_i (wide_q),
      .down_i (dir_q),
      .ptr_o  (ptr_nxt[g])
    );
  end

  strop_agen #(.SEG_W(SEG_W), .OFF_W(DATA_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_agen_src (
    .seg_i  (sseg_q),
    .off_i  (si_q),
    .addr_o (addr_src)
  );

  strop_agen #(.SEG_W(SEG_W), .OFF_W(DATA_W), .SHIFT(SHIFT), .ADDR_W(ADDR_W)) u_agen_dst (
    .seg_i  (dseg_q),
    .off_i  (di_q),
    .addr_o (addr_dst)
  );

  strop_zcmp #(.DATA_W(DATA_W)) u_zcmp (
    .lhs_i  ((op_q == OP_CMP) ? tmp_q : acc_q),
    .rhs_i  (mem_rdata),
    .wide_i (wide_q),
    .zero_o (cmp_zero)
  );

  assign rd_val       = wide_q ? mem_rdata : {{(DATA_W-BYTE_W){1'b0}}, mem_rdata[BYTE_W-1:0]};
  assign elem_done    = (st_q == ST_STEP);
  assign cx_exhausted = (rp_q != RP_NONE) && (cx_q == '0);
  assign cx_after     = (rp_q != RP_NONE) ? cx_q - DATA_W'(1) : cx_q;
  assign stop_now     = (rp_q == RP_NONE) || (cx_after == '0) ||
                        (sets_zf(op_q) && (((rp_q == RP_WHILE_EQ) && !zf_q) ||
                                           ((rp_q == RP_WHILE_NE) && zf_q)));

  // memory port
  assign mem_req   = (st_q == ST_RD_SRC) || (st_q == ST_RD_DST) || (st_q == ST_WR_DST);
  assign mem_we    = (st_q == ST_WR_DST);
  assign mem_wide  = wide_q;
  assign mem_addr  = (st_q == ST_RD_SRC) ? addr_src : addr_dst;
  assign wr_src    = (op_q == OP_MOVE) ? tmp_q : acc_q;
  assign mem_wdata = wide_q ? wr_src : {{(DATA_W-BYTE_W){1'b0}}, wr_src[BYTE_W-1:0]};
  assign xfer      = mem_req && mem_ready;

  // next state
  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE:   if (start) st_nxt = ST_CHECK;
      ST_CHECK: begin
        if (cx_exhausted) st_nxt = ST_DONE;
        else begin
          case (op_q)
            OP_MOVE, OP_CMP, OP_LOAD: st_nxt = ST_RD_SRC;
            OP_SCAN:                  st_nxt = ST_RD_DST;
            OP_STORE:                 st_nxt = ST_WR_DST;
            default:                  st_nxt = ST_DONE;
          endcase
        end
      end
      ST_RD_SRC: if (mem_ready) st_nxt = (op_q == OP_LOAD) ? ST_STEP :
                                         (op_q == OP_MOVE) ? ST_WR_DST : ST_RD_DST;
      ST_RD_DST: if (mem_ready) st_nxt = ST_STEP;
      ST_WR_DST: if (mem_ready) st_nxt = ST_STEP;
      ST_STEP:   st_nxt = stop_now ? ST_DONE : ST_CHECK;
      ST_DONE:   st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  // state and working registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_MOVE;
      rp_q   <= RP_NONE;
      wide_q <= 1'b0;
      dir_q  <= 1'b0;
      zf_q   <= 1'b0;
      sseg_q <= '0;
      dseg_q <= '0;
      si_q   <= '0;
      di_q   <= '0;
      cx_q   <= '0;
      acc_q  <= '0;
      tmp_q  <= '0;
    end else begin
      st_q <= st_nxt;
      if ((st_q == ST_IDLE) && start) begin
        op_q   <= sop_e'(op_sel);
        rp_q   <= rpt_e'(rep_mode);
        wide_q <= wide;
        dir_q  <= dir_down;
        sseg_q <= src_seg;
        dseg_q <= dst_seg;
        si_q   <= src_ptr_in;
        di_q   <= dst_ptr_in;
        cx_q   <= count_in;
        acc_q  <= acc_in;
        zf_q   <= zf_in;
      end
      if ((st_q == ST_RD_SRC) && mem_ready) begin
        tmp_q <= rd_val;
        if (op_q == OP_LOAD)
          acc_q <= wide_q ? mem_rdata : {acc_q[DATA_W-1:BYTE_W], mem_rdata[BYTE_W-1:0]};
      end
      if ((st_q == ST_RD_DST) && mem_ready) zf_q <= cmp_zero;
      if (elem_done) begin
        si_q <= ptr_nxt[0];
        di_q <= ptr_nxt[1];
        cx_q <= cx_after;
      end
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = (st_q == ST_DONE);
  assign src_ptr = si_q;
  assign dst_ptr = di_q;
  assign count   = cx_q;
  assign acc     = acc_q;
  assign zf      = zf_q;

  // assertions
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R9
  AST_WRITE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && mem_we) |-> ((op_q == OP_MOVE) || (op_q == OP_STORE))); // R9
  AST_CX_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && (rp_q != RP_NONE)) |=> (cx_q == $past(cx_q) - DATA_W'(1))); // R3
  AST_ONCE_CX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (rp_q == RP_NONE)) |=> $stable(cx_q)); // R5
  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_CHECK) && cx_exhausted) |=> (done && !mem_req)); // R4
  AST_ZF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !sets_zf(op_q)) |=> $stable(zf_q)); // R8
  AST_SRC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_done && reads_src(op_q)) |=>
      ((dir_q ? ($past(si_q) - si_q) : (si_q - $past(si_q))) == (wide_q ? DATA_W'(2) : DATA_W'(1)))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
endmodule

// File: tb/strop_seq_tb.sv
module strop_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 4096;
  localparam int WD_CYCLES  = 100000;
  localparam logic [15:0] DS_SEG = 16'h0010;
  localparam logic [15:0] ES_SEG = 16'h0080;

  typedef struct packed {
    logic [15:0] si;
    logic [15:0] di;
    logic [15:0] cx;
    logic [15:0] acc;
    logic        zf;
  } res_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [1:0]  rep_mode = '0;
  logic        wide = 1'b0;
  logic        dir_down = 1'b0;
  logic [15:0] src_ptr_in = '0, dst_ptr_in = '0, count_in = '0, acc_in = '0;
  logic        zf_in = 1'b0;
  logic        busy, done, zf, mem_req, mem_we, mem_wide;
  logic [15:0] src_ptr, dst_ptr, count, acc, mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic [19:0] mem_addr;

  logic [7:0] mem     [MEM_N];
  logic [7:0] ref_mem [MEM_N];
  res_t       exp_q[$];
  string      tag_q[$];
  int         n_tests = 0;
  int         n_fail  = 0;
  int         ri;

  always #(CLK_PERIOD/2) clk = ~clk;

  strop_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .rep_mode(rep_mode),
    .wide(wide), .dir_down(dir_down), .src_seg(DS_SEG), .dst_seg(ES_SEG),
    .src_ptr_in(src_ptr_in), .dst_ptr_in(dst_ptr_in), .count_in(count_in),
    .acc_in(acc_in), .zf_in(zf_in), .busy(busy), .done(done), .src_ptr(src_ptr),
    .dst_ptr(dst_ptr), .count(count), .acc(acc), .zf(zf), .mem_req(mem_req),
    .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder: one wait cycle per access, little-endian words
  always @(negedge clk) begin
    if (!rst_n) mem_ready <= 1'b0;
    else if (mem_req && !mem_ready) begin
      ri = int'(mem_addr[11:0]);
      if (mem_we) begin
        mem[ri] = mem_wdata[7:0];
        if (mem_wide) mem[(ri+1)%MEM_N] = mem_wdata[15:8];
      end else begin
        mem_rdata <= {mem_wide ? mem[(ri+1)%MEM_N] : 8'hEE, mem[ri]};
      end
      mem_ready <= 1'b1;
    end else mem_ready <= 1'b0;
  end

  function automatic int phys(logic [15:0] seg, logic [15:0] off);
    logic [19:0] p;
    p = {seg, 4'h0} + {4'h0, off};
    return int'(p[11:0]);
  endfunction

  function automatic logic [15:0] ref_rd(int i, logic w);
    return {w ? ref_mem[(i+1)%MEM_N] : 8'h00, ref_mem[i]};
  endfunction

  task automatic ref_wr(int i, logic w, logic [15:0] v);
    ref_mem[i] = v[7:0];
    if (w) ref_mem[(i+1)%MEM_N] = v[15:8];
  endtask

  task automatic poke(int i, logic [7:0] v);
    mem[i] = v;
    ref_mem[i] = v;
  endtask

  // independent model of the requirements
  task automatic ref_exec(input logic [2:0] op, input logic [1:0] rp, input logic wd, input logic dn,
                          input logic [15:0] si0, input logic [15:0] di0, input logic [15:0] cx0,
                          input logic [15:0] acc0, input logic zf0, output res_t r);
    logic [15:0] si, di, cx, ac, a, b, d;
    logic        z;
    bit          run;
    si = si0; di = di0; cx = cx0; ac = acc0; z = zf0;
    d = wd ? 16'd2 : 16'd1;
    run = !((rp != 2'd0) && (cx == 16'd0));
    while (run) begin
      case (op)
        3'd0: begin
          a = ref_rd(phys(DS_SEG, si), wd); ref_wr(phys(ES_SEG, di), wd, a);
          si = dn ? si - d : si + d; di = dn ? di - d : di + d;
        end
        3'd1: begin
          a = ref_rd(phys(DS_SEG, si), wd); b = ref_rd(phys(ES_SEG, di), wd);
          z = wd ? (a == b) : (a[7:0] == b[7:0]);
          si = dn ? si - d : si + d; di = dn ? di - d : di + d;
        end
        3'd2: begin
          b = ref_rd(phys(ES_SEG, di), wd);
          z = wd ? (ac == b) : (ac[7:0] == b[7:0]);
          di = dn ? di - d : di + d;
        end
        3'd3: begin
          a = ref_rd(phys(DS_SEG, si), wd);
          ac = wd ? a : {ac[15:8], a[7:0]};
          si = dn ? si - d : si + d;
        end
        default: begin
          ref_wr(phys(ES_SEG, di), wd, ac);
          di = dn ? di - d : di + d;
        end
      endcase
      if (rp == 2'd0) run = 0;
      else begin
        cx = cx - 16'd1;
        if (cx == 16'd0) run = 0;
        else if ((op == 3'd1 || op == 3'd2) && ((rp == 2'd2 && !z) || (rp == 2'd3 && z))) run = 0;
      end
    end
    r.si = si; r.di = di; r.cx = cx; r.acc = ac; r.zf = z;
  endtask

  // driver: predicts, pushes, starts and waits for the monitor to drain
  task automatic run_op(input logic [2:0] op, input logic [1:0] rp, input logic wd, input logic dn,
                        input logic [15:0] si, input logic [15:0] di, input logic [15:0] cx,
                        input logic [15:0] ac, input logic zfi, input string tag, input bit poke_start);
    res_t r;
    int   mism;
    ref_exec(op, rp, wd, dn, si, di, cx, ac, zfi, r);
    exp_q.push_back(r);
    tag_q.push_back(tag);
    @(negedge clk);
    op_sel = op; rep_mode = rp; wide = wd; dir_down = dn;
    src_ptr_in = si; dst_ptr_in = di; count_in = cx; acc_in = ac; zf_in = zfi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_start) begin
      repeat (2) @(negedge clk);
      op_sel = 3'd4; count_in = 16'h0000; acc_in = 16'hFFFF; src_ptr_in = 16'h0123;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk({tag, " R10 idle after done"}, {31'd0, busy}, 32'd0);
    mism = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) mism++;
    chk({tag, " memory image"}, mism, 32'd0);
  endtask

  // monitor: compares returned state at each done pulse
  initial begin
    res_t  e;
    string t;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) chk("R10 unexpected done", 32'd1, 32'd0);
        else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({t, " src_ptr"}, {16'd0, src_ptr}, {16'd0, e.si});
          chk({t, " dst_ptr"}, {16'd0, dst_ptr}, {16'd0, e.di});
          chk({t, " count"},   {16'd0, count},   {16'd0, e.cx});
          chk({t, " acc"},     {16'd0, acc},     {16'd0, e.acc});
          chk({t, " zf"},      {31'd0, zf},      {31'd0, e.zf});
        end
      end
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    chk("R10 reset done", {31'd0, done}, 32'd0);
    chk("R10 reset busy", {31'd0, busy}, 32'd0);
    chk("R9 reset no request", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R1: repeated byte copy upward, pointers end one past
    run_op(3'd0, 2'd1, 1'b0, 1'b0, 16'h0020, 16'h0040, 16'd5, 16'h0000, 1'b0, "R3 R1 rep copy bytes", 0);
    chk("R3 count zero", {16'd0, count}, 32'd0);
    chk("R3 src one past", {16'd0, src_ptr}, 32'h0025);
    chk("R3 dst one past", {16'd0, dst_ptr}, 32'h0045);
    // R2: repeated word copy downward
    run_op(3'd0, 2'd1, 1'b1, 1'b1, 16'h0060, 16'h0090, 16'd3, 16'h0000, 1'b1, "R2 rep copy words down", 0);
    // R5: single copy, count kept
    run_op(3'd0, 2'd0, 1'b0, 1'b0, 16'h0070, 16'h00A0, 16'd7, 16'h0000, 1'b0, "R5 single copy", 0);
    chk("R5 count kept", {16'd0, count}, 32'd7);
    // R4: zero count under repeat, no write
    run_op(3'd4, 2'd1, 1'b1, 1'b0, 16'h0011, 16'h00B0, 16'd0, 16'hBEEF, 1'b1, "R4 zero count store", 0);
    // R6 R7: compare while equal, mismatch at third byte
    poke(phys(DS_SEG, 16'h0010), 8'h41); poke(phys(DS_SEG, 16'h0011), 8'h42);
    poke(phys(DS_SEG, 16'h0012), 8'h43); poke(phys(DS_SEG, 16'h0013), 8'h44);
    poke(phys(ES_SEG, 16'h0010), 8'h41); poke(phys(ES_SEG, 16'h0011), 8'h42);
    poke(phys(ES_SEG, 16'h0012), 8'h58); poke(phys(ES_SEG, 16'h0013), 8'h44);
    run_op(3'd1, 2'd2, 1'b0, 1'b0, 16'h0010, 16'h0010, 16'd6, 16'h0000, 1'b1, "R6 R7 compare while equal", 0);
    chk("R7 stopped after third", {16'd0, count}, 32'd3);
    // R7: scan while not equal, target at fourth byte
    for (int k = 0; k < 10; k++) poke(phys(ES_SEG, 16'h0030 + 16'(k)), 8'h10 + 8'(k));
    poke(phys(ES_SEG, 16'h0033), 8'h5A);
    run_op(3'd2, 2'd3, 1'b0, 1'b0, 16'h0000, 16'h0030, 16'd10, 16'hFF5A, 1'b0, "R7 R6 scan while not equal", 0);
    chk("R7 scan found", {16'd0, count}, 32'd6);
    // R8: single word load keeps zf
    run_op(3'd3, 2'd0, 1'b1, 1'b0, 16'h0044, 16'h0000, 16'd2, 16'h1111, 1'b1, "R8 load word", 0);
    // R8: repeated byte store
    run_op(3'd4, 2'd1, 1'b0, 1'b0, 16'h0000, 16'h00C0, 16'd4, 16'hA5C3, 1'b0, "R8 rep store bytes", 0);
    // R7: scan words while equal, all match
    for (int k = 0; k < 3; k++) begin
      poke(phys(ES_SEG, 16'h0050 + 16'(2*k)), 8'h34);
      poke(phys(ES_SEG, 16'h0051 + 16'(2*k)), 8'h12);
    end
    run_op(3'd2, 2'd2, 1'b1, 1'b0, 16'h0000, 16'h0050, 16'd3, 16'h1234, 1'b0, "R7 scan words all equal", 0);
    chk("R7 all equal zf", {31'd0, zf}, 32'd1);
    // R7: count-only mode ignores the flag on compare
    run_op(3'd1, 2'd1, 1'b0, 1'b0, 16'h0010, 16'h0010, 16'd4, 16'h0000, 1'b0, "R7 count-only compare", 0);
    // R8 R2: byte load downward keeps high accumulator byte
    run_op(3'd3, 2'd0, 1'b0, 1'b1, 16'h0015, 16'h0000, 16'd0, 16'h7700, 1'b0, "R8 R2 load byte down", 0);
    chk("R8 high byte kept", {24'd0, acc[15:8]}, 32'h77);
    // R10: start while busy has no effect
    run_op(3'd0, 2'd1, 1'b1, 1'b0, 16'h0100, 16'h0100, 16'd3, 16'h0000, 1'b0, "R10 start while busy", 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule